// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port with Input Debounce

This block is a 32-line general-purpose I/O port behind a zero-wait APB-style register slave. Software drives the pads through an output-data register and an output-enable register. It reads the pad levels back after a two-flop synchronizer. Every line can also raise an interrupt. The interrupt for a line is either level-sensitive or edge-latched, has a selectable active polarity, and is gated by an enable bit and a mask bit.

Latched edges are acknowledged by writing ones to an acknowledge register. Any line can pass through a glitch filter clocked by a slow tick input before it reaches the detector. The per-line gated interrupt status is offered as a vector, and the OR of that vector is offered as a single request line. A build-time parameter moves five of the interrupt registers to a second address arrangement, so that two software views are served by one design.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register is zero, so pin_out, pin_oe, irq_vec and irq are all zero.
- R2: Data written to offset 0x00 appears on pin_out and data written to 0x04 appears on pin_oe. Both read back. They change only on a write to their own offset.
- R3: Reading offset 0x50 returns pin_in delayed by exactly two clock edges.
- R4: A line whose type bit is 0 is level-sensitive. With polarity 1 it is active while high, and with polarity 0 while low. Its status follows the input and is never latched.
- R5: A line whose type bit is 1 is edge-sensitive. Polarity 1 latches a rising edge and polarity 0 latches a falling edge. The latched bit stays set after the input settles.
- R6: A mask bit of 1 keeps that line out of irq_vec and irq. A latched edge survives while masked and shows up once the mask is cleared.
- R7: Writing a 1 to a bit of the acknowledge register clears that line's latched edge and no other line's. Writing all ones clears every latched edge. Acknowledge writes do not affect level-sensitive lines.
- R8: An edge detected in the same cycle as an acknowledge write for its line stays latched.
- R9: Clearing a line's enable bit erases its latched edge, and a disabled line latches nothing.
- R10: irq_vec equals enable AND NOT mask AND pending, irq is the OR of irq_vec, and the status register reads irq_vec.
- R11: With its debounce bit set, a line's filtered value changes only after two consecutive db_tick samples see the same new level. A level seen on one tick only is dropped.
- R12: With ALT_MAP=1, the mask register sits at 0x44, type at 0x34, polarity at 0x38, status at 0x3C and acknowledge at 0x40. All other offsets are unchanged. In the default map, 0x44 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 7 | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, zero while not selected |
| db_tick | input | 1 | Slow sampling strobe for the debounce filter |
| pin_in | input | 32 | Asynchronous pad inputs |
| pin_out | output | 32 | Pad output data |
| pin_oe | output | 32 | Pad output enables |
| irq | output | 1 | Combined interrupt request |
| irq_vec | output | 32 | Per-line gated interrupt status |

## Verification
The bench builds two instances side by side on one set of pins. One uses the default map and the other uses ALT_MAP=1, both with the debounce filter built in. The default instance carries the random level and edge sweeps and the directed acknowledge, mask, enable and debounce cases. The alternate instance shows that the relocated mask, type, polarity, status and acknowledge offsets act on the same logic, and that the default map leaves the relocated mask offset empty.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [3:0] {
        RID_NONE,
        RID_DOUT,
        RID_DIR,
        RID_IEN,
        RID_IMASK,
        RID_ITYPE,
        RID_IPOL,
        RID_ISTAT,
        RID_DBEN,
        RID_EOI,
        RID_EXT
    } reg_id_e;

    // Offset decode; five interrupt registers move when alt is set.
    function automatic reg_id_e reg_lookup(input logic [7:0] off, input logic alt);
        reg_id_e id;
        case (off)
            8'h00:   id = RID_DOUT;
            8'h04:   id = RID_DIR;
            8'h30:   id = RID_IEN;
            8'h48:   id = RID_DBEN;
            8'h50:   id = RID_EXT;
            default: id = RID_NONE;
        endcase
        if (alt) begin
            case (off)
                8'h44:   id = RID_IMASK;
                8'h34:   id = RID_ITYPE;
                8'h38:   id = RID_IPOL;
                8'h3C:   id = RID_ISTAT;
                8'h40:   id = RID_EOI;
                default: ;
            endcase
        end else begin
            case (off)
                8'h34:   id = RID_IMASK;
                8'h38:   id = RID_ITYPE;
                8'h3C:   id = RID_IPOL;
                8'h40:   id = RID_ISTAT;
                8'h4C:   id = RID_EOI;
                default: ;
            endcase
        end
        return id;
    endfunction

endpackage

// File: rtl/gpio_irq_filter.sv
module gpio_irq_filter #(
    parameter int NPIN     = 32,
    parameter bit DEBOUNCE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_in,
    input  logic            db_tick,
    input  logic [NPIN-1:0] db_en,
    output logic [NPIN-1:0] pin_sync,
    output logic [NPIN-1:0] pin_eff
);

    typedef struct packed {
        logic [NPIN-1:0] s1;
        logic [NPIN-1:0] s2;
        logic [NPIN-1:0] smp;
        logic [NPIN-1:0] filt;
    } flt_t;

    flt_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_in;
        st_d.s2 = st_q.s1;
        if (db_tick) begin
            st_d.smp = st_q.s2;
            for (int i = 0; i < NPIN; i++) begin
                if (st_q.s2[i] == st_q.smp[i]) begin
                    st_d.filt[i] = st_q.s2[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_sync = st_q.s2;

    generate
        if (DEBOUNCE) begin : g_db
            assign pin_eff = (db_en & st_q.filt) | (~db_en & st_q.s2);
        end else begin : g_nodb
            assign pin_eff = st_q.s2;
        end
    endgenerate

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPIN    = 32,
    parameter int AW      = 7,
    parameter bit ALT_MAP = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            psel,
    input  logic            penable,
    input  logic            pwrite,
    input  logic [AW-1:0]   paddr,
    input  logic [NPIN-1:0] pwdata,
    output logic [NPIN-1:0] prdata,
    input  logic [NPIN-1:0] pin_sync,
    input  logic [NPIN-1:0] status,
    output logic [NPIN-1:0] dout,
    output logic [NPIN-1:0] dir,
    output logic [NPIN-1:0] ien,
    output logic [NPIN-1:0] imask,
    output logic [NPIN-1:0] itype,
    output logic [NPIN-1:0] ipol,
    output logic [NPIN-1:0] dben,
    output logic [NPIN-1:0] eoi
);

    typedef struct packed {
        logic [NPIN-1:0] dout;
        logic [NPIN-1:0] dir;
        logic [NPIN-1:0] ien;
        logic [NPIN-1:0] imask;
        logic [NPIN-1:0] itype;
        logic [NPIN-1:0] ipol;
        logic [NPIN-1:0] dben;
    } cfg_t;

    cfg_t            cfg_d, cfg_q;
    reg_id_e         rid;
    logic            wr_en;
    logic [NPIN-1:0] rd_val;

    assign rid   = reg_lookup(8'(paddr), ALT_MAP);
    assign wr_en = psel & penable & pwrite;

    always_comb begin
        cfg_d = cfg_q;
        eoi   = '0;
        if (wr_en) begin
            case (rid)
                RID_DOUT:  cfg_d.dout  = pwdata;
                RID_DIR:   cfg_d.dir   = pwdata;
                RID_IEN:   cfg_d.ien   = pwdata;
                RID_IMASK: cfg_d.imask = pwdata;
                RID_ITYPE: cfg_d.itype = pwdata;
                RID_IPOL:  cfg_d.ipol  = pwdata;
                RID_DBEN:  cfg_d.dben  = pwdata;
                RID_EOI:   eoi         = pwdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (rid)
            RID_DOUT:  rd_val = cfg_q.dout;
            RID_DIR:   rd_val = cfg_q.dir;
            RID_IEN:   rd_val = cfg_q.ien;
            RID_IMASK: rd_val = cfg_q.imask;
            RID_ITYPE: rd_val = cfg_q.itype;
            RID_IPOL:  rd_val = cfg_q.ipol;
            RID_DBEN:  rd_val = cfg_q.dben;
            RID_ISTAT: rd_val = status;
            RID_EXT:   rd_val = pin_sync;
            default:   rd_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign prdata = psel ? rd_val : '0;
    assign dout   = cfg_q.dout;
    assign dir    = cfg_q.dir;
    assign ien    = cfg_q.ien;
    assign imask  = cfg_q.imask;
    assign itype  = cfg_q.itype;
    assign ipol   = cfg_q.ipol;
    assign dben   = cfg_q.dben;

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_eff,
    input  logic [NPIN-1:0] ien,
    input  logic [NPIN-1:0] imask,
    input  logic [NPIN-1:0] itype,
    input  logic [NPIN-1:0] ipol,
    input  logic [NPIN-1:0] eoi,
    output logic [NPIN-1:0] edge_hit,
    output logic [NPIN-1:0] pend_q,
    output logic [NPIN-1:0] status
);

    typedef struct packed {
        logic [NPIN-1:0] prev;
        logic [NPIN-1:0] pend;
    } det_t;

    det_t            st_d, st_q;
    logic [NPIN-1:0] lvl_act;
    logic [NPIN-1:0] live;

    always_comb begin
        edge_hit  = (ipol & pin_eff & ~st_q.prev) | (~ipol & ~pin_eff & st_q.prev);
        lvl_act   = ~(pin_eff ^ ipol);
        st_d.prev = pin_eff;
        // A fresh edge outranks an acknowledge in the same cycle.
        st_d.pend = itype & ien & ((st_q.pend & ~eoi) | edge_hit);
        live      = (itype & st_q.pend) | (~itype & lvl_act);
        status    = ien & ~imask & live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q = st_q.pend;

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
    parameter int NPIN     = 32,
    parameter int AW       = 7,
    parameter bit ALT_MAP  = 1'b0,
    parameter bit DEBOUNCE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            psel,
    input  logic            penable,
    input  logic            pwrite,
    input  logic [AW-1:0]   paddr,
    input  logic [NPIN-1:0] pwdata,
    output logic [NPIN-1:0] prdata,
    input  logic            db_tick,
    input  logic [NPIN-1:0] pin_in,
    output logic [NPIN-1:0] pin_out,
    output logic [NPIN-1:0] pin_oe,
    output logic            irq,
    output logic [NPIN-1:0] irq_vec
);

    logic [NPIN-1:0] ien, imask, itype, ipol, dben, eoi;
    logic [NPIN-1:0] pin_sync, pin_eff;
    logic [NPIN-1:0] edge_hit, pend_q, status;

    gpio_irq_regs #(
        .NPIN    (NPIN),
        .AW      (AW),
        .ALT_MAP (ALT_MAP)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .pin_sync (pin_sync),
        .status   (status),
        .dout     (pin_out),
        .dir      (pin_oe),
        .ien      (ien),
        .imask    (imask),
        .itype    (itype),
        .ipol     (ipol),
        .dben     (dben),
        .eoi      (eoi)
    );

    gpio_irq_filter #(
        .NPIN     (NPIN),
        .DEBOUNCE (DEBOUNCE)
    ) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .db_tick  (db_tick),
        .db_en    (dben),
        .pin_sync (pin_sync),
        .pin_eff  (pin_eff)
    );

    gpio_irq_detect #(
        .NPIN (NPIN)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_eff  (pin_eff),
        .ien      (ien),
        .imask    (imask),
        .itype    (itype),
        .ipol     (ipol),
        .eoi      (eoi),
        .edge_hit (edge_hit),
        .pend_q   (pend_q),
        .status   (status)
    );

    assign irq_vec = status;
    assign irq     = |status;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
    parameter int NPIN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            psel,
    input logic            penable,
    input logic            pwrite,
    input logic [NPIN-1:0] pin_in,
    input logic [NPIN-1:0] pin_out,
    input logic [NPIN-1:0] pin_oe,
    input logic [NPIN-1:0] irq_vec,
    input logic [NPIN-1:0] ien,
    input logic [NPIN-1:0] imask,
    input logic [NPIN-1:0] itype,
    input logic [NPIN-1:0] ipol,
    input logic [NPIN-1:0] pend_q,
    input logic [NPIN-1:0] edge_hit,
    input logic [NPIN-1:0] pin_eff,
    input logic [NPIN-1:0] pin_sync
);

    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    p_hold_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite) |=> ($stable(pin_out) && $stable(pin_oe)));

    p_sync_delay_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (pin_sync == $past(pin_in, 2)));

    p_level_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_vec ^ (ien & ~imask & ~(pin_eff ^ ipol))) & ~itype) == '0);

    p_edge_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_hit & ien & itype) != '0) |=>
        ((pend_q & $past(edge_hit & ien & itype)) == $past(edge_hit & ien & itype)));

    p_mask_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_vec & (imask | ~ien)) == '0);

    p_disable_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & ~$past(ien)) == '0));

endmodule

bind gpio_irq_port gpio_irq_chk #(.NPIN(NPIN)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .pin_in   (pin_in),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .irq_vec  (irq_vec),
    .ien      (ien),
    .imask    (imask),
    .itype    (itype),
    .ipol     (ipol),
    .pend_q   (pend_q),
    .edge_hit (edge_hit),
    .pin_eff  (pin_eff),
    .pin_sync (pin_sync)
);

// File: tb/gpio_irq_port_test.sv
`timescale 1ns/1ps
module gpio_irq_port_test;

    localparam logic [7:0] A_DOUT = 8'h00, A_DIR = 8'h04, A_IEN = 8'h30, A_MASK = 8'h34,
                           A_TYPE = 8'h38, A_POL = 8'h3C, A_STAT = 8'h40, A_DBEN = 8'h48,
                           A_EOI = 8'h4C, A_EXT = 8'h50;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [1:0]  psel = '0;
    logic        penable = 1'b0, pwrite = 1'b0, db_tick = 1'b0;
    logic [6:0]  paddr = '0;
    logic [31:0] pwdata = '0, pins = '0;
    wire  [31:0] prd0, prd1, out0, out1, oe0, oe1, vec0, vec1;
    wire         irq0, irq1;
    int          checks = 0, errors = 0;
    bit          finished = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_port #(.ALT_MAP(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel[0]), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prd0), .db_tick(db_tick), .pin_in(pins),
        .pin_out(out0), .pin_oe(oe0), .irq(irq0), .irq_vec(vec0));

    gpio_irq_port #(.ALT_MAP(1'b1)) uut_alt (
        .clk(clk), .rst_n(rst_n), .psel(psel[1]), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prd1), .db_tick(db_tick), .pin_in(pins),
        .pin_out(out1), .pin_oe(oe1), .irq(irq1), .irq_vec(vec1));

    function automatic logic [31:0] lvl_exp(input logic [31:0] p, en, m, pol);
        return en & ~m & ~(p ^ pol);
    endfunction

    function automatic logic [31:0] edge_exp(input logic [31:0] a, b, en, m, pol);
        return en & ~m & ((pol & b & ~a) | (~pol & a & ~b));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int u, input logic [7:0] a, input logic [31:0] d);
        psel[u] = 1'b1; pwrite = 1'b1; paddr = a[6:0]; pwdata = d; penable = 1'b0;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = '0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input int u, input logic [7:0] a, output logic [31:0] d);
        psel[u] = 1'b1; pwrite = 1'b0; paddr = a[6:0]; penable = 1'b0;
        #1 d = (u == 1) ? prd1 : prd0;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = '0; penable = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick();
        db_tick = 1'b1;
        @(negedge clk);
        db_tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, en, m, pol, a, b, e;
        void'($urandom(32'h5eed_0042));
        idle(3); rst_n = 1'b1; idle(1);

        // R1 reset state
        check("R1 pin_out", out0, '0);
        check("R1 pin_oe", oe0, '0);
        check("R1 irq_vec", vec0, '0);
        check("R1 irq", {31'b0, irq0}, '0);
        rd(0, A_IEN, r); check("R1 enable reg", r, '0);

        // R2 output data and direction
        wr(0, A_DOUT, 32'hDEADBEEF);
        wr(0, A_DIR, 32'h0000FFFF);
        check("R2 pin_out", out0, 32'hDEADBEEF);
        check("R2 pin_oe", oe0, 32'h0000FFFF);
        rd(0, A_DOUT, r); check("R2 readback", r, 32'hDEADBEEF);
        check("R2 untouched", out0, 32'hDEADBEEF);

        // R3 two-flop synchronizer on readback
        pins = 32'h12345678;
        @(negedge clk);
        rd(0, A_EXT, r); check("R3 one edge old", r, 32'h0);
        rd(0, A_EXT, r); check("R3 synced", r, 32'h12345678);

        // R4 R10 random level sweep
        for (int i = 0; i < 16; i++) begin
            en = $urandom; m = $urandom; pol = $urandom; a = $urandom;
            wr(0, A_IEN, en); wr(0, A_MASK, m); wr(0, A_POL, pol);
            pins = a; idle(3);
            e = lvl_exp(a, en, m, pol);
            check("R4 level vec", vec0, e);
            check("R10 irq or", {31'b0, irq0}, {31'b0, (e != 0)});
            rd(0, A_STAT, r); check("R10 status reg", r, e);
        end

        // R5 random edge sweep
        wr(0, A_TYPE, 32'hFFFFFFFF);
        for (int i = 0; i < 12; i++) begin
            en = $urandom; m = $urandom; pol = $urandom; a = $urandom; b = $urandom;
            wr(0, A_MASK, m); wr(0, A_POL, pol); wr(0, A_IEN, en);
            pins = a; idle(4);
            wr(0, A_EOI, 32'hFFFFFFFF);
            pins = b; idle(4);
            check("R5 edge vec", vec0, edge_exp(a, b, en, m, pol));
        end

        // directed: lines 0,1 edge, line 2 level active-low
        wr(0, A_IEN, 0); pins = 0; idle(4);
        wr(0, A_TYPE, 32'h3); wr(0, A_POL, 32'h1); wr(0, A_MASK, 32'h1); wr(0, A_IEN, 32'h7);
        pins = 32'h3; idle(4);
        check("R6 masked edge hidden", vec0, 32'h4);
        pins = 32'h1; idle(4);
        check("R5 falling latched", vec0, 32'h6);
        pins = 32'h5; idle(3);
        check("R4 level not latched", vec0, 32'h2);
        wr(0, A_MASK, 32'h0);
        check("R6 pending kept under mask", vec0, 32'h3);
        wr(0, A_EOI, 32'h1);
        check("R7 ack single line", vec0, 32'h2);
        pins = 32'h1; idle(3);
        check("R4 level active low", vec0, 32'h6);
        wr(0, A_EOI, 32'hFFFFFFFF);
        check("R7 ack all, level kept", vec0, 32'h4);

        // R9 enable clear erases, disabled never latches
        pins = 32'h0; idle(4);
        pins = 32'h1; idle(4);
        check("R9 setup pending", vec0, 32'h5);
        wr(0, A_IEN, 32'h6); wr(0, A_IEN, 32'h7);
        check("R9 erased by disable", vec0, 32'h4);
        wr(0, A_IEN, 32'h6);
        pins = 32'h0; idle(4);
        pins = 32'h1; idle(4);
        wr(0, A_IEN, 32'h7);
        check("R9 no latch while disabled", vec0, 32'h4);

        // R8 edge and acknowledge in the same cycle
        pins = 32'h0; idle(4); wr(0, A_EOI, 32'h1);
        pins = 32'h1;
        @(negedge clk);
        wr(0, A_EOI, 32'h1);
        check("R8 edge beats ack", vec0 & 32'h1, 32'h1);
        wr(0, A_EOI, 32'h1);
        check("R7 later ack clears", vec0 & 32'h1, 32'h0);

        // R11 debounce on line 5
        wr(0, A_IEN, 0); pins = 0; idle(4);
        wr(0, A_TYPE, 0); wr(0, A_POL, 32'hFFFFFFFF); wr(0, A_DBEN, 32'h20);
        wr(0, A_MASK, 0); wr(0, A_IEN, 32'h20);
        check("R11 idle low", vec0, 32'h0);
        pins = 32'h20; idle(4);
        check("R11 no tick yet", vec0, 32'h0);
        tick(); check("R11 one tick", vec0, 32'h0);
        tick(); check("R11 two ticks", vec0, 32'h20);
        pins = 32'h0; idle(3);
        tick(); check("R11 glitch one tick", vec0, 32'h20);
        pins = 32'h20; idle(3);
        tick(); check("R11 glitch dropped", vec0, 32'h20);
        tick(); check("R11 stays high", vec0, 32'h20);

        // R12 alternate map
        pins = 0; idle(4);
        wr(1, 8'h44, 32'hA5A5A5A5);
        rd(1, 8'h44, r); check("R12 alt mask", r, 32'hA5A5A5A5);
        rd(1, 8'h34, r); check("R12 alt type", r, 32'h0);
        rd(0, 8'h44, r); check("R12 default empty", r, 32'h0);
        wr(1, 8'h34, 32'h1); wr(1, 8'h38, 32'h1);
        wr(1, 8'h44, 32'hFFFFFFFE); wr(1, 8'h30, 32'h1);
        pins = 32'h1; idle(4);
        check("R12 alt edge", vec1, 32'h1);
        rd(1, 8'h3C, r); check("R12 alt status", r, 32'h1);
        wr(1, 8'h40, 32'h1);
        check("R12 alt ack", vec1, 32'h0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule